// File: doc/BRIEF.md
# Packet Page Allocator and Queue Manager

This block keeps track of a small pool of fixed-size packet buffer pages inside a network controller. Pages are handed out lowest-number-first from an occupancy bitmask, either to software through an allocate-for-transmit command or to the receive path through a one-cycle request. Three page-number FIFOs sit beside the pool. One holds pages waiting to be sent. One holds sent pages that software has not yet reclaimed. The last holds received pages waiting to be read.

Software drives the block through a 3-bit command code. The register decoder takes it from bits 7:5 of the byte written to the command register. Software also supplies a current packet number, an interrupt-acknowledge byte and an interrupt-enable byte. The transmit engine reports each sent page with a strobe, together with an auto-release level. An eight-bit interrupt status register and a single level interrupt line follow the queue state. Frame storage, the MAC and address decode belong to the surrounding controller.

Top module: `pg_mmu`

## Requirements
- R1: The pool holds NPAGES pages (default 4). Every allocation takes the lowest-numbered free page. `used_count` reports how many pages are currently allocated.
- R2: Command codes are: 0 no-op, 1 allocate for transmit, 2 MMU reset, 3 pop receive queue, 4 pop receive queue and free its head page, 5 free `pkt_num`, 6 enqueue `pkt_num` for transmit, 7 flush transmit and completion queues. Only one operation is carried out per cycle, with priority `cmd_we` > `ack_we` > `tx_sent` > `rx_alloc_req`. `mask_we` acts independently of all of them.
- R3: Code 1 first sets `tx_alloc_res` to 0x80 and clears status bit 3 (ALLOC), then allocates. On success `tx_alloc_res` holds the page number (upper bits zero) and bit 3 is set. When the pool is full, the result stays 0x80.
- R4: Freeing a page clears its bit. If `tx_alloc_res` equals 0x80 at that moment, the allocation is retried in the same cycle, and on success it updates the result and sets bit 3 as in R3.
- R5: Code 6 appends `pkt_num` to the transmit queue. It is ignored when the queue already holds NPAGES entries.
- R6: When `tx_sent` is pulsed with a non-empty transmit queue, the head is popped. If `auto_rel` is high, that page is freed, with the retry of R4. Otherwise the page is appended to the completion queue if it has room.
- R7: `rx_alloc_req` allocates the lowest free page, appends it to the receive queue and sets status bit 0 (RCV). It has no effect when the pool is full.
- R8: Code 3 pops the receive queue. Code 4 frees the head page and then pops. After either pop, bit 0 stays set if entries remain and clears if the queue is empty. Both codes do nothing on an empty receive queue.
- R9: Code 2 empties the bitmask and all three queues and sets `tx_alloc_res` to 0. Code 7 empties only the transmit and completion queues. Code 0 changes nothing.
- R10: `tx_head`, `done_head` and `rx_head` show the head page number, or 0x80 when their queue is empty.
- R11: Status bit 2 (TX_EMPTY) is set in every cycle in which the transmit queue is empty. Status bit 1 (TX) is set in every cycle in which the completion queue is non-empty. Both remain set until acknowledged.
- R12: An acknowledge clears the status bits in (`ack_byte` AND 0xD6), so bits 3 and 0 cannot be cleared this way. If bit 1 of `ack_byte` is set, the completion queue is popped as well.
- R13: `irq` is high exactly when (`int_status` AND `int_mask`) is non-zero. `mask_we` loads `int_mask` from `mask_byte`.
- R14: After reset, no page is allocated, all queues are empty, `tx_alloc_res` is 0, `int_status` is 0x04, `int_mask` is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (bits 7:5 of the command byte) |
| pkt_num | input | PW | Current packet number |
| tx_sent | input | 1 | Transmit engine finished the head page |
| auto_rel | input | 1 | Free sent pages instead of queuing them |
| rx_alloc_req | input | 1 | Receive path requests a page |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| tx_alloc_res | output | 8 | Transmit allocation result |
| tx_head | output | 8 | Transmit queue head or 0x80 |
| done_head | output | 8 | Completion queue head or 0x80 |
| rx_head | output | 8 | Receive queue head or 0x80 |
| used_count | output | PW+1 | Number of allocated pages |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted bitmask shows up on the next allocation. The result or `used_count` then differs from the lowest-free rule within one cycle of the command. A FIFO pointer or count fault shows at a head port only once that queue is popped or refilled, so the bench pops every queue until it is empty and checks the 0x80 marker. Sticky-bit faults in the status register can stay hidden until an acknowledge with the queue still non-empty. The sequence therefore acknowledges TX_EMPTY and TX in both states of their queues.

// File: rtl/pg_mmu_pkg.sv
package pg_mmu_pkg;

    typedef enum logic [2:0] {
        CMD_NOP         = 3'd0,
        CMD_TX_ALLOC    = 3'd1,
        CMD_MMU_RESET   = 3'd2,
        CMD_RX_POP      = 3'd3,
        CMD_RX_POP_FREE = 3'd4,
        CMD_FREE        = 3'd5,
        CMD_TX_PUSH     = 3'd6,
        CMD_TX_FLUSH    = 3'd7
    } mmu_cmd_e;

    localparam logic [7:0] NO_PAGE       = 8'h80;
    localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
    localparam logic [7:0] STATUS_RESET  = 8'h04;

    localparam int ST_ALLOC   = 3;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TX      = 1;
    localparam int ST_RCV     = 0;

    // Head-port encoding: page number when valid, empty marker otherwise.
    function automatic logic [7:0] page_byte(input logic valid, input logic [31:0] page);
        return valid ? 8'(page) : NO_PAGE;
    endfunction

endpackage

// File: rtl/pg_fifo.sv
module pg_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         empty_nx
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt, cnt_nx;
    logic [AW-1:0] wr_idx;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign wr_idx  = rd_ptr + cnt[AW-1:0];
    assign head    = mem[rd_ptr];

    always_comb begin
        if (clr)
            cnt_nx = '0;
        else
            cnt_nx = cnt + CW'(do_push) - CW'(do_pop);
    end
    assign empty_nx = (cnt_nx == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop)
                rd_ptr <= rd_ptr + AW'(1);
            cnt <= cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr)
            mem[wr_idx] <= push_data;
    end
endmodule

// File: rtl/pg_pool.sv
module pg_pool #(
    parameter int NPAGES = 4,
    localparam int PW    = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          rel_en,
    input  logic [PW-1:0] rel_idx,
    input  logic          alloc_en,
    output logic          avail,
    output logic [PW-1:0] grant_idx,
    output logic [PW:0]   used
);
    logic [NPAGES-1:0] bits_q, after_rel, grant_oh;

    always_comb begin
        after_rel = bits_q;
        if (rel_en)
            after_rel[rel_idx] = 1'b0;
    end

    // Lowest free page of the mask that already reflects this cycle's release.
    always_comb begin
        avail     = 1'b0;
        grant_idx = '0;
        for (int i = NPAGES - 1; i >= 0; i--) begin
            if (!after_rel[i]) begin
                avail     = 1'b1;
                grant_idx = PW'(i);
            end
        end
    end

    always_comb begin
        grant_oh = '0;
        if (alloc_en && avail)
            grant_oh[grant_idx] = 1'b1;
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < NPAGES; i++)
            used = used + (PW+1)'(bits_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            bits_q <= '0;
        else
            bits_q <= after_rel | grant_oh;
    end
endmodule

// File: rtl/pg_mmu.sv
module pg_mmu
    import pg_mmu_pkg::*;
#(
    parameter int NPAGES = 4,
    localparam int PW    = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_we,
    input  logic [2:0]    cmd_code,
    input  logic [PW-1:0] pkt_num,
    input  logic          tx_sent,
    input  logic          auto_rel,
    input  logic          rx_alloc_req,
    input  logic          ack_we,
    input  logic [7:0]    ack_byte,
    input  logic          mask_we,
    input  logic [7:0]    mask_byte,
    output logic [7:0]    tx_alloc_res,
    output logic [7:0]    tx_head,
    output logic [7:0]    done_head,
    output logic [7:0]    rx_head,
    output logic [PW:0]   used_count,
    output logic [7:0]    int_status,
    output logic [7:0]    int_mask,
    output logic          irq
);
    mmu_cmd_e cmd;
    assign cmd = mmu_cmd_e'(cmd_code);

    logic          do_cmd, do_ack, do_sent, do_rx;
    assign do_cmd  = cmd_we;
    assign do_ack  = !cmd_we && ack_we;
    assign do_sent = !cmd_we && !ack_we && tx_sent;
    assign do_rx   = !cmd_we && !ack_we && !tx_sent && rx_alloc_req;

    // Pool and queue wiring
    logic          rel_en, alloc_en, pool_clr, avail;
    logic [PW-1:0] rel_idx, grant_idx;
    logic          tq_push, tq_pop, tq_clr, tq_empty, tq_full, tq_empty_nx;
    logic          dq_push, dq_pop, dq_clr, dq_empty, dq_full, dq_empty_nx;
    logic          rq_push, rq_pop, rq_clr, rq_empty, rq_full, rq_empty_nx;
    logic [PW-1:0] tq_head, dq_head, rq_head, rq_second;
    logic          rq_more;

    logic [7:0]    res_q, res_nx, stat_q, stat_nx, mask_q;

    pg_pool #(.NPAGES(NPAGES)) i_pool (
        .clk(clk), .rst(rst), .clr(pool_clr),
        .rel_en(rel_en), .rel_idx(rel_idx), .alloc_en(alloc_en),
        .avail(avail), .grant_idx(grant_idx), .used(used_count)
    );

    pg_fifo #(.DEPTH(NPAGES), .W(PW)) i_txq (
        .clk(clk), .rst(rst), .clr(tq_clr), .push(tq_push), .push_data(pkt_num),
        .pop(tq_pop), .head(tq_head), .empty(tq_empty), .full(tq_full),
        .empty_nx(tq_empty_nx)
    );

    pg_fifo #(.DEPTH(NPAGES), .W(PW)) i_doneq (
        .clk(clk), .rst(rst), .clr(dq_clr), .push(dq_push), .push_data(tq_head),
        .pop(dq_pop), .head(dq_head), .empty(dq_empty), .full(dq_full),
        .empty_nx(dq_empty_nx)
    );

    pg_fifo #(.DEPTH(NPAGES), .W(PW)) i_rxq (
        .clk(clk), .rst(rst), .clr(rq_clr), .push(rq_push), .push_data(grant_idx),
        .pop(rq_pop), .head(rq_head), .empty(rq_empty), .full(rq_full),
        .empty_nx(rq_empty_nx)
    );

    // Entries remain after a pop exactly when the queue will not be empty next cycle.
    assign rq_more   = !rq_empty_nx;
    assign rq_second = rq_head;

    // Release decode: kept apart from the allocation decode so that the
    // pool's post-release availability never loops back into this block.
    always_comb begin
        rel_en  = 1'b0;
        rel_idx = '0;
        if (do_cmd) begin
            case (cmd)
                CMD_RX_POP_FREE: begin
                    rel_en  = !rq_empty;
                    rel_idx = rq_head;
                end
                CMD_FREE: begin
                    rel_en  = 1'b1;
                    rel_idx = pkt_num;
                end
                default: ;
            endcase
        end else if (do_sent && !tq_empty && auto_rel) begin
            rel_en  = 1'b1;
            rel_idx = tq_head;
        end
    end

    always_comb begin
        alloc_en = 1'b0;
        pool_clr = 1'b0;
        tq_push  = 1'b0;  tq_pop = 1'b0;  tq_clr = 1'b0;
        dq_push  = 1'b0;  dq_pop = 1'b0;  dq_clr = 1'b0;
        rq_push  = 1'b0;  rq_pop = 1'b0;  rq_clr = 1'b0;
        res_nx   = res_q;
        stat_nx  = stat_q;

        // A release with an allocation still pending retries it at once.
        if (rel_en && res_q == NO_PAGE && avail) begin
            alloc_en          = 1'b1;
            res_nx            = page_byte(1'b1, 32'(grant_idx));
            stat_nx[ST_ALLOC] = 1'b1;
        end

        if (do_cmd) begin
            case (cmd)
                CMD_TX_ALLOC: begin
                    res_nx            = NO_PAGE;
                    stat_nx[ST_ALLOC] = 1'b0;
                    if (avail) begin
                        alloc_en          = 1'b1;
                        res_nx            = page_byte(1'b1, 32'(grant_idx));
                        stat_nx[ST_ALLOC] = 1'b1;
                    end
                end
                CMD_MMU_RESET: begin
                    pool_clr = 1'b1;
                    tq_clr   = 1'b1;
                    dq_clr   = 1'b1;
                    rq_clr   = 1'b1;
                    alloc_en = 1'b0;
                    res_nx   = '0;
                end
                CMD_RX_POP, CMD_RX_POP_FREE: begin
                    if (!rq_empty) begin
                        rq_pop          = 1'b1;
                        stat_nx[ST_RCV] = rq_more;
                    end
                end
                CMD_TX_PUSH:  tq_push = 1'b1;
                CMD_TX_FLUSH: begin
                    tq_clr = 1'b1;
                    dq_clr = 1'b1;
                end
                default: ;
            endcase
        end else if (do_ack) begin
            stat_nx = stat_q & ~(ack_byte & ACK_CLEARABLE);
            dq_pop  = ack_byte[ST_TX];
        end else if (do_sent) begin
            if (!tq_empty) begin
                tq_pop  = 1'b1;
                dq_push = !auto_rel;
            end
        end else if (do_rx) begin
            if (avail) begin
                alloc_en        = 1'b1;
                rq_push         = 1'b1;
                stat_nx[ST_RCV] = 1'b1;
            end
        end

        if (tq_empty_nx)
            stat_nx[ST_TXEMPTY] = 1'b1;
        if (!dq_empty_nx)
            stat_nx[ST_TX] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            stat_q <= STATUS_RESET;
            mask_q <= '0;
        end else begin
            res_q  <= res_nx;
            stat_q <= stat_nx;
            if (mask_we)
                mask_q <= mask_byte;
        end
    end

    assign tx_alloc_res = res_q;
    assign tx_head      = page_byte(!tq_empty, 32'(tq_head));
    assign done_head    = page_byte(!dq_empty, 32'(dq_head));
    assign rx_head      = page_byte(!rq_empty, 32'(rq_second));
    assign int_status   = stat_q;
    assign int_mask     = mask_q;
    assign irq          = |(stat_q & mask_q);

    // Full flags are consumed inside the queues; the receive queue can never
    // overflow because it holds at most one entry per page.
    logic unused_ok;
    assign unused_ok = &{1'b0, tq_full, dq_full, rq_full};
endmodule

// File: rtl/pg_mmu_chk.sv
module pg_mmu_chk #(
    parameter int NPAGES = 4,
    localparam int PW    = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_we,
    input logic [2:0]  cmd_code,
    input logic [7:0]  tx_alloc_res,
    input logic [7:0]  tx_head,
    input logic [7:0]  done_head,
    input logic [7:0]  rx_head,
    input logic [PW:0] used_count,
    input logic [7:0]  int_status
);
    p_used_bound_r1: assert property (@(posedge clk) disable iff (rst)
        used_count <= (PW+1)'(NPAGES));

    p_alloc_ok_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_code == 3'd1 && used_count < (PW+1)'(NPAGES))
        |=> (int_status[3] && tx_alloc_res != 8'h80));

    p_alloc_full_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_code == 3'd1 && used_count == (PW+1)'(NPAGES))
        |=> (tx_alloc_res == 8'h80 && !int_status[3]));

    p_mmu_reset_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_code == 3'd2)
        |=> (used_count == '0 && tx_alloc_res == 8'h00 && rx_head == 8'h80
             && tx_head == 8'h80 && done_head == 8'h80));

    p_txempty_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_head == 8'h80) |=> int_status[2]);

    p_txdone_r11: assert property (@(posedge clk) disable iff (rst)
        (done_head != 8'h80) |-> int_status[1]);

    p_rcv_held_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_head != 8'h80) |-> int_status[0]);
endmodule

bind pg_mmu pg_mmu_chk #(.NPAGES(NPAGES)) i_chk (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .tx_alloc_res(tx_alloc_res), .tx_head(tx_head), .done_head(done_head),
    .rx_head(rx_head), .used_count(used_count), .int_status(int_status)
);

// File: tb/test_pg_mmu.sv
module test_pg_mmu;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 0, tx_sent = 0, auto_rel = 0, rx_alloc_req = 0;
    logic       ack_we = 0, mask_we = 0;
    logic [2:0] cmd_code = 0;
    logic [1:0] pkt_num = 0;
    logic [7:0] ack_byte = 0, mask_byte = 0;
    logic [7:0] tx_alloc_res, tx_head, done_head, rx_head, int_status, int_mask;
    logic [2:0] used_count;
    logic       irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_mmu #(.NPAGES(NP)) i_pg_mmu (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code), .pkt_num(pkt_num),
        .tx_sent(tx_sent), .auto_rel(auto_rel), .rx_alloc_req(rx_alloc_req),
        .ack_we(ack_we), .ack_byte(ack_byte), .mask_we(mask_we), .mask_byte(mask_byte),
        .tx_alloc_res(tx_alloc_res), .tx_head(tx_head), .done_head(done_head),
        .rx_head(rx_head), .used_count(used_count), .int_status(int_status),
        .int_mask(int_mask), .irq(irq)
    );

    typedef struct {
        string      tag;
        logic [7:0] res, txh, dh, rxh, st, mk;
        logic [2:0] used;
        logic       irq;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0;
    bit   finished = 0;

    // Reference model state
    logic [3:0] m_bits = 0;
    logic [7:0] m_res = 0, m_st = 8'h04, m_mk = 0;
    int         tq[$], dq[$], rq[$];

    task automatic chk(string tag, string name, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, name, act, expv);
        end
    endtask

    function automatic int m_lowest();
        for (int i = 0; i < NP; i++)
            if (!m_bits[i]) return i;
        return -1;
    endfunction

    function automatic void m_release(int p);
        int l;
        m_bits[p] = 1'b0;
        if (m_res == 8'h80) begin
            l = m_lowest();
            if (l >= 0) begin
                m_bits[l] = 1'b1;
                m_res = 8'(l);
                m_st[3] = 1'b1;
            end
        end
    endfunction

    function automatic logic [7:0] hb(int q[$]);
        return (q.size() == 0) ? 8'h80 : 8'(q[0]);
    endfunction

    function automatic void m_cmd(logic [2:0] c, logic [1:0] pk);
        int l, p;
        case (c)
            3'd1: begin
                m_res = 8'h80; m_st[3] = 1'b0;
                l = m_lowest();
                if (l >= 0) begin m_bits[l] = 1'b1; m_res = 8'(l); m_st[3] = 1'b1; end
            end
            3'd2: begin m_bits = 0; tq.delete(); dq.delete(); rq.delete(); m_res = 0; end
            3'd3, 3'd4: if (rq.size() > 0) begin
                p = rq.pop_front();
                if (c == 3'd4) m_release(p);
                m_st[0] = (rq.size() > 0);
            end
            3'd5: m_release(int'(pk));
            3'd6: if (tq.size() < NP) tq.push_back(int'(pk));
            3'd7: begin tq.delete(); dq.delete(); end
            default: ;
        endcase
    endfunction

    // Driver: applies one cycle of stimulus and records the expected outcome.
    task automatic drive(string tag, bit c, logic [2:0] code, logic [1:0] pk,
                         bit s, bit au, bit rx, bit a, logic [7:0] av,
                         bit m, logic [7:0] mv);
        exp_t e;
        int l, p;
        @(negedge clk);
        cmd_we = c; cmd_code = code; pkt_num = pk; tx_sent = s; auto_rel = au;
        rx_alloc_req = rx; ack_we = a; ack_byte = av; mask_we = m; mask_byte = mv;
        if (c) m_cmd(code, pk);
        else if (a) begin
            m_st = m_st & ~(av & 8'hD6);
            if (av[1] && dq.size() > 0) void'(dq.pop_front());
        end else if (s) begin
            if (tq.size() > 0) begin
                p = tq.pop_front();
                if (au) m_release(p);
                else if (dq.size() < NP) dq.push_back(p);
            end
        end else if (rx) begin
            l = m_lowest();
            if (l >= 0) begin m_bits[l] = 1'b1; rq.push_back(l); m_st[0] = 1'b1; end
        end
        if (m) m_mk = mv;
        if (tq.size() == 0) m_st[2] = 1'b1;
        if (dq.size() != 0) m_st[1] = 1'b1;
        e.tag = tag; e.res = m_res; e.txh = hb(tq); e.dh = hb(dq); e.rxh = hb(rq);
        e.st = m_st; e.mk = m_mk; e.used = 3'($countones(m_bits)); e.irq = |(m_st & m_mk);
        exp_q.push_back(e);
    endtask

    task automatic op_cmd(string tag, logic [2:0] code, logic [1:0] pk = 0);
        drive(tag, 1, code, pk, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic op_ack(string tag, logic [7:0] v);
        drive(tag, 0, 0, 0, 0, 0, 0, 1, v, 0, 0);
    endtask
    task automatic op_mask(string tag, logic [7:0] v);
        drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, v);
    endtask
    task automatic op_sent(string tag, bit au);
        drive(tag, 0, 0, 0, 1, au, 0, 0, 0, 0, 0);
    endtask
    task automatic op_rx(string tag);
        drive(tag, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    // Monitor: compares the registered outputs just after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "tx_alloc_res", tx_alloc_res, e.res);
                chk(e.tag, "tx_head", tx_head, e.txh);
                chk(e.tag, "done_head", done_head, e.dh);
                chk(e.tag, "rx_head", rx_head, e.rxh);
                chk(e.tag, "int_status", int_status, e.st);
                chk(e.tag, "int_mask", int_mask, e.mk);
                chk(e.tag, "used_count", 8'(used_count), 8'(e.used));
                chk(e.tag, "irq", 8'(irq), 8'(e.irq));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R14 reset state
        chk("R14", "tx_alloc_res", tx_alloc_res, 8'h00);
        chk("R14", "int_status", int_status, 8'h04);
        chk("R14", "heads", tx_head & done_head & rx_head, 8'h80);
        chk("R14", "used_count", 8'(used_count), 8'h00);
        chk("R14", "irq", 8'(irq), 8'h00);

        op_mask("R13", 8'hFF);
        op_cmd("R1", 3'd1); op_cmd("R1", 3'd1); op_cmd("R3", 3'd1); op_cmd("R3", 3'd1);
        op_cmd("R3", 3'd1);              // pool full: result stays 0x80
        op_cmd("R4", 3'd5, 2'd2);        // free page 2, pending alloc retried
        op_cmd("R2", 3'd0);              // no-op
        op_cmd("R5", 3'd6, 2'd0); op_cmd("R5", 3'd6, 2'd1);
        op_cmd("R5", 3'd6, 2'd2); op_cmd("R5", 3'd6, 2'd3);
        op_cmd("R5", 3'd6, 2'd0);        // queue full: ignored
        op_sent("R6", 0); op_sent("R6", 0);
        op_ack("R12", 8'h02);            // pops completion queue, TX stays set
        op_ack("R11", 8'h04);            // transmit queue not empty: bit clears
        op_ack("R12", 8'hFF);            // ALLOC and RCV survive
        op_sent("R6", 1);                // auto release, no pending allocation
        op_mask("R13", 8'h00);
        op_cmd("R10", 3'd1);
        op_rx("R7");                     // pool full: no effect
        op_cmd("R4", 3'd5, 2'd0);
        op_rx("R7");
        op_cmd("R9", 3'd7);              // flush transmit and completion queues
        drive("R2", 1, 3'd0, 0, 0, 0, 1, 0, 0, 0, 0); // command wins over receive
        op_cmd("R4", 3'd5, 2'd1); op_cmd("R4", 3'd5, 2'd3);
        op_rx("R7"); op_rx("R7");
        op_mask("R13", 8'h01);
        op_cmd("R8", 3'd3); op_cmd("R8", 3'd4); op_cmd("R8", 3'd4);
        op_cmd("R8", 3'd3);              // empty receive queue: no effect
        op_cmd("R3", 3'd1); op_cmd("R3", 3'd1); op_cmd("R3", 3'd1);
        op_cmd("R5", 3'd6, 2'd1);
        op_sent("R6", 1);                // auto release retries pending allocation
        op_ack("R11", 8'h04);            // queue empty: TX_EMPTY stays
        op_cmd("R9", 3'd2);
        op_cmd("R1", 3'd1);

        @(negedge clk);
        cmd_we = 0; tx_sent = 0; rx_alloc_req = 0; ack_we = 0; mask_we = 0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule